// File: doc/BRIEF.md
# Byte-Pair Timer/Counter Channel

This block is one 16-bit timer/counter channel in the classic microcontroller style. Its count lives in two byte registers, a high byte and a low byte. Each clock it may advance by one. The event that advances it is either the core clock itself (timer use) or a falling edge seen on an external event pin (counter use). A run bit enables counting. An optional gate bit also requires an external gate pin to be high.

Two width modes are provided. In the prescaled mode the low five bits of the low byte divide by 32 and feed an 8-bit high byte, giving a 13-bit count. In the cascaded mode both bytes form one 16-bit counter. When the count wraps from its maximum to zero, a sticky overflow flag is raised. Either byte can be loaded through its own byte-wide write port, and a clear strobe drops the flag.

Top module: `tcu_timer_channel`

## Requirements
- R1: While `rst` is high at a clock edge, both count bytes and the overflow flag become zero and the pin sample register becomes low. All of them read zero after reset.
- R2: With `ext_sel`=0, the channel enabled, `mode`=01 and no write, the 16-bit count `{cnt_hi,cnt_lo}` grows by exactly one on every clock.
- R3: With `ext_sel`=1, an event is counted only at a clock edge where `evt_pin` is low and its sample from the previous edge was high. A pin held high or held low adds nothing. A pin that is already high when reset ends adds nothing. Alternating the pin every clock counts once per two clocks.
- R4: Counting is enabled only when `run_en`=1 and either `gate_en`=0 or `gate_pin`=1. When it is not enabled, the count holds.
- R5: With `mode`=00, each event increments `cnt_lo[4:0]` modulo 32. `cnt_hi` increments only when `cnt_lo[4:0]` was 31. `cnt_lo[7:5]` never changes except by a write. Overflow is raised when `cnt_hi`=FF and `cnt_lo[4:0]`=31 at an event.
- R6: With `mode`=01, an event at `{cnt_hi,cnt_lo}`=FFFF gives 0000 and raises the overflow flag.
- R7: `ovf_flag` stays set until a clock with `ovf_clr`=1. If a wrap happens in that same clock, the flag stays set.
- R8: A write to a byte (`lo_wr` or `hi_wr`) loads its data at the next clock. Any write in a clock suppresses counting for that clock in both bytes, and the byte that is not written holds its value.
- R9: With `mode`=10 or 11, no event changes the count and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run control bit |
| gate_en | input | 1 | When 1, counting also needs gate_pin high |
| ext_sel | input | 1 | 1: count evt_pin falling edges, 0: count clocks |
| mode | input | 2 | 00 prescaled 13-bit, 01 cascaded 16-bit, 1x hold |
| evt_pin | input | 1 | External event input |
| gate_pin | input | 1 | External gate input |
| lo_wr | input | 1 | Load strobe for the low byte |
| lo_wdata | input | 8 | Low byte load value |
| hi_wr | input | 1 | Load strobe for the high byte |
| hi_wdata | input | 8 | High byte load value |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Every result is due one clock edge after the inputs that cause it. That covers the count step, a load, the flag set or clear, and an external edge: the pin is compared against its previous sample inside the same edge that counts it. The bench drives all inputs one nanosecond after a rising edge. It works out the next state from a model of the requirements at that moment. It then compares all three outputs one nanosecond after the following rising edge, so each comparison sits exactly one register stage after its stimulus.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;
    localparam int CASC_W = 2 * BYTE_W;
    localparam int LANES  = 2;

    localparam logic [PRE_W-1:0]  PRE_MAX  = '1;
    localparam logic [BYTE_W-1:0] BYTE_MAX = '1;

    typedef enum logic [1:0] {
        TM_PRE13  = 2'b00,
        TM_CASC16 = 2'b01,
        TM_RSVD2  = 2'b10,
        TM_RSVD3  = 2'b11
    } tcu_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } tcu_count_t;

    typedef struct packed {
        tcu_count_t count;
        logic       wrap;
    } tcu_step_t;

    typedef struct packed {
        logic run;
        logic gate_en;
        logic gate_pin;
        logic ext_sel;
    } tcu_ctl_t;

    function automatic tcu_step_t tcu_advance(tcu_count_t cur, tcu_mode_e m);
        tcu_step_t          s;
        logic [PRE_W-1:0]   pre;
        logic [BYTE_W:0]    hi_sum;
        logic [CASC_W:0]    full_sum;
        s.count  = cur;
        s.wrap   = 1'b0;
        pre      = cur.lo[PRE_W-1:0];
        hi_sum   = {1'b0, cur.hi} + (BYTE_W+1)'(1);
        full_sum = {1'b0, cur.hi, cur.lo} + (CASC_W+1)'(1);
        case (m)
            TM_PRE13: begin
                s.count.lo[PRE_W-1:0] = pre + PRE_W'(1);
                if (pre == PRE_MAX) begin
                    s.count.hi = hi_sum[BYTE_W-1:0];
                    s.wrap     = hi_sum[BYTE_W];
                end
            end
            TM_CASC16: begin
                {s.count.hi, s.count.lo} = full_sum[CASC_W-1:0];
                s.wrap                   = full_sum[CASC_W];
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tcu_edge_sampler.sv
module tcu_edge_sampler (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic samp_q;

    always_ff @(posedge clk) begin
        if (rst) samp_q <= 1'b0;
        else     samp_q <= pin;
    end

    assign fall = samp_q & ~pin;

    AST_FALL_SPACED: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);                                          // R3
    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        fall |-> ($past(pin) && !$past(rst)));                    // R3

endmodule

// File: rtl/tcu_run_gate.sv
module tcu_run_gate
    import tcu_pkg::*;
(
    input  tcu_ctl_t ctl,
    input  logic     fall,
    output logic     tick
);
    logic enabled;
    logic source_evt;

    assign enabled    = ctl.run & (~ctl.gate_en | ctl.gate_pin);
    assign source_evt = ctl.ext_sel ? fall : 1'b1;
    assign tick       = enabled & source_evt;

endmodule

// File: rtl/tcu_count_core.sv
module tcu_count_core
    import tcu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  tcu_mode_e             mode,
    input  logic [LANES-1:0]      wr_v,
    input  logic [CASC_W-1:0]     wr_data,
    input  logic                  ovf_clr,
    output tcu_count_t            count,
    output logic                  ovf
);
    tcu_count_t        cnt_q;
    tcu_count_t        cnt_nxt;
    tcu_step_t         step;
    logic              advance_en;
    logic              ovf_q;
    logic [CASC_W-1:0] cur_flat;
    logic [CASC_W-1:0] adv_flat;
    logic [CASC_W-1:0] nxt_flat;

    assign step       = tcu_advance(cnt_q, mode);
    assign advance_en = tick & ~(|wr_v);
    assign cur_flat   = {cnt_q.hi, cnt_q.lo};
    assign adv_flat   = {step.count.hi, step.count.lo};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign nxt_flat[g*BYTE_W +: BYTE_W] =
            wr_v[g]    ? wr_data[g*BYTE_W +: BYTE_W] :
            advance_en ? adv_flat[g*BYTE_W +: BYTE_W] :
                         cur_flat[g*BYTE_W +: BYTE_W];
    end

    assign cnt_nxt = tcu_count_t'(nxt_flat);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            ovf_q <= (advance_en & step.wrap) | (ovf_q & ~ovf_clr);
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr) |=> ovf_q);                                   // R7
    AST_CASC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mode == TM_CASC16 && tick && wr_v == '0 && cnt_q == '1)
            |=> (ovf_q && cnt_q == '0));                                  // R6
    AST_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_v[0] |=> cnt_q.lo == $past(wr_data[BYTE_W-1:0]));              // R8
    AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_v[1] |=> cnt_q.hi == $past(wr_data[CASC_W-1:BYTE_W]));         // R8
    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && wr_v == '0) |=> $stable(cnt_q));                      // R9
    AST_PRE_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == TM_PRE13 && !wr_v[0])
            |=> cnt_q.lo[BYTE_W-1:PRE_W] == $past(cnt_q.lo[BYTE_W-1:PRE_W])); // R5

endmodule

// File: rtl/tcu_timer_channel.sv
module tcu_timer_channel
    import tcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              gate_en,
    input  logic              ext_sel,
    input  logic [1:0]        mode,
    input  logic              evt_pin,
    input  logic              gate_pin,
    input  logic              lo_wr,
    input  logic [BYTE_W-1:0] lo_wdata,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] hi_wdata,
    input  logic              ovf_clr,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic              ovf_flag
);
    tcu_ctl_t   ctl;
    tcu_count_t count;
    logic       fall;
    logic       tick;

    assign ctl = '{run: run_en, gate_en: gate_en, gate_pin: gate_pin, ext_sel: ext_sel};

    tcu_edge_sampler u_sampler (
        .clk  (clk),
        .rst  (rst),
        .pin  (evt_pin),
        .fall (fall)
    );

    tcu_run_gate u_gate (
        .ctl  (ctl),
        .fall (fall),
        .tick (tick)
    );

    tcu_count_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (tcu_mode_e'(mode)),
        .wr_v    ({hi_wr, lo_wr}),
        .wr_data ({hi_wdata, lo_wdata}),
        .ovf_clr (ovf_clr),
        .count   (count),
        .ovf     (ovf_flag)
    );

    assign cnt_lo = count.lo;
    assign cnt_hi = count.hi;

    AST_RUN_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !lo_wr && !hi_wr) |=> $stable({cnt_hi, cnt_lo}));     // R4
    AST_GATE_CLOSED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !gate_pin && !lo_wr && !hi_wr) |=> $stable({cnt_hi, cnt_lo})); // R4
    AST_PIN_STEADY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ext_sel && !lo_wr && !hi_wr && $stable(evt_pin) && !$past(rst))
            |=> $stable({cnt_hi, cnt_lo}));                               // R3

endmodule

// File: tb/tcu_timer_channel_bench.sv
module tcu_timer_channel_bench;

    logic       clk = 1'b0;
    logic       rst, run_en, gate_en, ext_sel, evt_pin, gate_pin;
    logic [1:0] mode;
    logic       lo_wr, hi_wr, ovf_clr;
    logic [7:0] lo_wdata, hi_wdata;
    logic [7:0] cnt_lo, cnt_hi;
    logic       ovf_flag;

    logic [7:0] m_lo, m_hi;
    logic       m_ovf, m_samp;
    int         total = 0;
    int         bad   = 0;
    bit         done  = 0;

    always #4 clk = ~clk;

    tcu_timer_channel u_tcu_timer_channel (
        .clk(clk), .rst(rst), .run_en(run_en), .gate_en(gate_en),
        .ext_sel(ext_sel), .mode(mode), .evt_pin(evt_pin), .gate_pin(gate_pin),
        .lo_wr(lo_wr), .lo_wdata(lo_wdata), .hi_wr(hi_wr), .hi_wdata(hi_wdata),
        .ovf_clr(ovf_clr), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input logic [7:0] elo, input logic [7:0] ehi,
                       input logic eovf);
        total++;
        if (cnt_lo !== elo || cnt_hi !== ehi || ovf_flag !== eovf) begin
            bad++;
            $display("FAIL %s: got hi=%02h lo=%02h ovf=%0b, want hi=%02h lo=%02h ovf=%0b",
                     tag, cnt_hi, cnt_lo, ovf_flag, ehi, elo, eovf);
        end
    endtask

    // Model of the requirements: next state from current inputs.
    task automatic cyc(input string tag);
        logic [7:0]  nlo, nhi;
        logic        novf, tick, wrap;
        logic [16:0] s17;
        logic [8:0]  h9;
        nlo = m_lo; nhi = m_hi; wrap = 1'b0;
        tick = run_en && (!gate_en || gate_pin) && (ext_sel ? (m_samp && !evt_pin) : 1'b1);
        if (lo_wr || hi_wr) begin
            if (lo_wr) nlo = lo_wdata;
            if (hi_wr) nhi = hi_wdata;
        end else if (tick) begin
            if (mode == 2'b00) begin
                nlo[4:0] = m_lo[4:0] + 5'd1;
                if (m_lo[4:0] == 5'd31) begin
                    h9 = {1'b0, m_hi} + 9'd1;
                    nhi = h9[7:0];
                    wrap = h9[8];
                end
            end else if (mode == 2'b01) begin
                s17 = {1'b0, m_hi, m_lo} + 17'd1;
                {nhi, nlo} = s17[15:0];
                wrap = s17[16];
            end
        end
        novf = wrap || (m_ovf && !ovf_clr);
        @(posedge clk);
        if (rst) begin
            m_lo = 0; m_hi = 0; m_ovf = 0; m_samp = 0;
        end else begin
            m_lo = nlo; m_hi = nhi; m_ovf = novf; m_samp = evt_pin;
        end
        #1;
        chk(tag, m_lo, m_hi, m_ovf);
    endtask

    task automatic quiet();
        lo_wr = 0; hi_wr = 0; ovf_clr = 0;
    endtask

    task automatic load(input logic [7:0] h, input logic [7:0] l, input string tag);
        hi_wr = 1; hi_wdata = h; lo_wr = 1; lo_wdata = l;
        cyc(tag);
        quiet();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; run_en = 1; gate_en = 0; ext_sel = 1; mode = 2'b01;
        evt_pin = 1; gate_pin = 0; lo_wdata = 0; hi_wdata = 0;
        m_lo = 0; m_hi = 0; m_ovf = 0; m_samp = 0;
        quiet();
        #1;
        cyc("R1");
        cyc("R1");
        chk("R1 reset state", 8'h00, 8'h00, 1'b0);
        rst = 0;
        // R3: pin high from reset, held high: no count
        repeat (4) cyc("R3");
        chk("R3 high from reset", 8'h00, 8'h00, 1'b0);
        evt_pin = 0; cyc("R3");
        chk("R3 first fall", 8'h01, 8'h00, 1'b0);
        repeat (3) cyc("R3");
        for (int i = 0; i < 10; i++) begin evt_pin = ~evt_pin; cyc("R3"); end
        chk("R3 half rate", 8'h06, 8'h00, 1'b0);
        // R2: timer mode
        ext_sel = 0; load(8'h00, 8'h00, "R8");
        repeat (10) cyc("R2");
        chk("R2 ten clocks", 8'h0A, 8'h00, 1'b0);
        // R4: gating
        gate_en = 1; gate_pin = 0;
        repeat (5) cyc("R4");
        chk("R4 gate closed", 8'h0A, 8'h00, 1'b0);
        gate_pin = 1; repeat (3) cyc("R4");
        chk("R4 gate open", 8'h0D, 8'h00, 1'b0);
        run_en = 0; repeat (3) cyc("R4");
        chk("R4 run off", 8'h0D, 8'h00, 1'b0);
        run_en = 1; gate_en = 0; gate_pin = 0;
        // R5: prescaled mode wrap
        mode = 2'b00; load(8'hFF, 8'hFE, "R8");
        cyc("R5");
        chk("R5 pre at 31", 8'hFF, 8'hFF, 1'b0);
        cyc("R5");
        chk("R5 wrap", 8'hE0, 8'h00, 1'b1);
        ovf_clr = 1; cyc("R7"); quiet();
        chk("R7 clear", 8'hE1, 8'h00, 1'b0);
        load(8'h07, 8'hBF, "R8");
        cyc("R5");
        chk("R5 carry to hi", 8'hA0, 8'h08, 1'b0);
        // R6: cascaded wrap, set wins over clear
        mode = 2'b01; load(8'hFF, 8'hFF, "R8");
        ovf_clr = 1; cyc("R6"); quiet();
        chk("R6 wrap with clear", 8'h00, 8'h00, 1'b1);
        repeat (3) cyc("R7");
        chk("R7 sticky", 8'h03, 8'h00, 1'b1);
        // R8: single byte write suppresses counting
        lo_wr = 1; lo_wdata = 8'h55; cyc("R8"); quiet();
        chk("R8 lo load", 8'h55, 8'h00, 1'b1);
        hi_wr = 1; hi_wdata = 8'h12; cyc("R8"); quiet();
        chk("R8 hi load", 8'h55, 8'h12, 1'b1);
        // R9: reserved modes hold
        mode = 2'b10; repeat (4) cyc("R9");
        mode = 2'b11; repeat (4) cyc("R9");
        chk("R9 hold", 8'h55, 8'h12, 1'b1);
        ovf_clr = 1; cyc("R7"); quiet();
        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            run_en   = (r != 0);
            gate_en  = 1'($urandom);
            gate_pin = ($urandom % 4) != 0;
            ext_sel  = ($urandom % 3) == 0;
            evt_pin  = 1'($urandom);
            mode     = (($urandom % 8) == 0) ? 2'($urandom) : {1'b0, 1'($urandom)};
            lo_wr    = ($urandom % 20) == 0;
            hi_wr    = ($urandom % 20) == 0;
            lo_wdata = (($urandom % 2) == 0) ? 8'hFF : 8'($urandom);
            hi_wdata = (($urandom % 2) == 0) ? 8'hFF : 8'($urandom);
            ovf_clr  = ($urandom % 16) == 0;
            rst      = ($urandom % 1000) == 0;
            if (rst)               cyc("R1");
            else if (lo_wr || hi_wr) cyc("R8");
            else if (mode == 2'b00) cyc("R5");
            else if (mode == 2'b01) cyc("R6");
            else                    cyc("R9");
        end
        rst = 0; quiet();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule